// File: doc/BRIEF.md
# Streaming Vector-Prefix Decoder

This block sits at the front of an instruction decoder and takes instruction bytes one per cycle over a valid/ready handshake. It recognises three kinds of prefix:

- the compact two-byte vector-extension prefix, led by C5h;
- the compact three-byte vector-extension prefix, led by C4h;
- the one-byte REX register-extension prefix.

For each instruction it emits one record. The record carries the register-extension bits, the W bit, the extra source register, the vector-length bit, the legacy SIMD prefix that the vector prefix stands for, the opcode map and the opcode byte.

A mode input selects 64-bit or 32-bit operation. In 32-bit mode, C4h and C5h are also the opcodes of two legacy far-pointer loads. The block settles which one it has by looking at the byte after the lead byte without consuming it. The block also flags illegal encodings: a map select it does not support, or a vector prefix that follows other prefixes.

Bytes after the opcode (addressing, displacement, immediate) belong to later stages. The caller must not present them to this block. After each record the block is back in its idle state and treats the next byte as the start of a new instruction.

Top module: `vpfx_stream_decoder`

## Requirements
- R1: While a record is held with rec_valid high and rec_ready low, in_ready is low and every record output stays unchanged.
- R2: Lead byte C5h starts the two-byte form. Its payload byte gives, from bit 7 down: inverted R, inverted 4-bit register specifier, L, and pp. The record then has X=0, B=0, W=0 and map 1, and the opcode is the byte after the payload.
- R3: Lead byte C4h starts the three-byte form. In the first payload byte, bits 7:5 are inverted R, X and B, and bits 4:0 are the map select. In the second payload byte, bit 7 is W, bits 6:3 are the inverted register specifier, bit 2 is L and bits 1:0 are pp. The record outputs R, X, B and the register specifier un-inverted.
- R4: rec_simd reports the implied legacy prefix: pp 00 gives 00h, 01 gives 66h, 10 gives F3h and 11 gives F2h.
- R5: A three-byte form whose map select is 0 or greater than 3 sets rec_illegal.
- R6: A vector prefix that is preceded in the same instruction by 66h, F2h, F3h or a REX byte sets rec_illegal.
- R7: In 32-bit mode, if the byte after C4h/C5h does not have bits 7:6 equal to 11, a pass-through record is emitted. That record has rec_passthru=1, rec_opcode=C4h/C5h, and all other fields 0. The look-ahead byte is not consumed (in_ready is low for it), so it becomes the first byte of the next instruction.
- R8: In 32-bit mode, a vector record always has R, X and B equal to 0.
- R9: In 64-bit mode, C4h and C5h are always prefixes, whatever the next byte holds. A byte 0100WRXB is a REX prefix, and the next plain opcode record carries rec_rex=1 and W, R, X, B as written. In 32-bit mode, 40h–4Fh are plain opcodes.
- R10: A plain opcode record has rec_vec=0, rec_illegal=0, and a register specifier, L, SIMD code and map of 0. Any 66h, F2h or F3h bytes before the opcode do not change it.
- R11: After reset, rec_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode; change only between instructions |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| rec_ready | input | 1 | Downstream accepts the record |
| rec_valid | output | 1 | Record valid |
| rec_vec | output | 1 | Record comes from a vector prefix |
| rec_rex | output | 1 | Plain opcode carried a REX prefix |
| rec_passthru | output | 1 | Lead byte passed through as a legacy opcode |
| rec_illegal | output | 1 | Illegal encoding |
| rec_w | output | 1 | W bit |
| rec_r | output | 1 | Register-field extension |
| rec_x | output | 1 | Index extension |
| rec_b | output | 1 | Base / r/m extension |
| rec_vvvv | output | 4 | Extra source register, un-inverted |
| rec_l | output | 1 | Vector length bit |
| rec_simd | output | 8 | Implied legacy SIMD prefix byte |
| rec_map | output | 5 | Opcode map select |
| rec_opcode | output | 8 | Opcode byte |

## Verification
The hardest situation to reach from the ports is the 32-bit look-ahead. In that case a lead byte is pending, the byte that follows is refused, and it must then start the next instruction, possibly while an earlier record is still held by back-pressure. Random batches in 32-bit mode mix pass-through cases with vector and plain instructions. A pass-through case is always followed by an opcode below C0h, and rec_ready is dropped at random so that a held record and a refused look-ahead byte meet. Directed cases add the edge values: a legacy prefix in front of a pass-through, a 64-bit C4h followed by 00h, and 4xh in both modes.

// File: rtl/vpfx_stream_decoder.sv
module vpfx_stream_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode64,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       rec_ready,
  output logic       rec_valid,
  output logic       rec_vec,
  output logic       rec_rex,
  output logic       rec_passthru,
  output logic       rec_illegal,
  output logic       rec_w,
  output logic       rec_r,
  output logic       rec_x,
  output logic       rec_b,
  output logic [3:0] rec_vvvv,
  output logic       rec_l,
  output logic [7:0] rec_simd,
  output logic [4:0] rec_map,
  output logic [7:0] rec_opcode
);

  localparam logic [7:0] OSZ  = 8'h66;
  localparam logic [7:0] REPZ = 8'hF3;
  localparam logic [7:0] REPN = 8'hF2;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_PAY2, S_OPC} st_t;
  st_t st;

  logic       form3, leg_seen, rex_seen;
  logic [3:0] rex_bits;
  logic       ax_r, ax_x, ax_b, ax_w, ax_l;
  logic [3:0] ax_vvvv;
  logic [1:0] ax_pp;
  logic [4:0] ax_map;

  function automatic logic [7:0] pp_code(input logic [1:0] pp);
    case (pp)
      2'd1:    pp_code = OSZ;
      2'd2:    pp_code = REPZ;
      2'd3:    pp_code = REPN;
      default: pp_code = 8'h00;
    endcase
  endfunction

  wire can_take   = !rec_valid || rec_ready;
  wire la_pass    = (st == S_LEAD) && !mode64 && (in_data[7:6] != 2'b11);
  assign in_ready = can_take && !la_pass;
  wire fire       = in_valid && in_ready;
  wire pass_fire  = in_valid && can_take && la_pass;

  wire is_leg = (in_data == OSZ) || (in_data == REPZ) || (in_data == REPN);
  wire is_rex = mode64 && (in_data[7:4] == 4'h4);
  wire is_vex = (in_data[7:1] == 7'b1100010);

  wire emit_plain = fire && (st == S_IDLE) && !is_leg && !is_rex && !is_vex;
  wire emit_vec   = fire && (st == S_OPC);
  wire map_bad    = form3 && ((ax_map == 5'd0) || (ax_map > 5'd3));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      form3 <= 1'b0;
      leg_seen <= 1'b0;
      rex_seen <= 1'b0;
      rex_bits <= '0;
      ax_r <= 1'b0; ax_x <= 1'b0; ax_b <= 1'b0; ax_w <= 1'b0; ax_l <= 1'b0;
      ax_vvvv <= '0;
      ax_pp <= '0;
      ax_map <= '0;
      rec_valid <= 1'b0;
      rec_vec <= 1'b0; rec_rex <= 1'b0; rec_passthru <= 1'b0; rec_illegal <= 1'b0;
      rec_w <= 1'b0; rec_r <= 1'b0; rec_x <= 1'b0; rec_b <= 1'b0;
      rec_vvvv <= '0; rec_l <= 1'b0; rec_simd <= '0; rec_map <= '0; rec_opcode <= '0;
    end else begin
      if (rec_valid && rec_ready) rec_valid <= 1'b0;

      if (fire) begin
        case (st)
          S_IDLE: begin
            if (is_leg) leg_seen <= 1'b1;
            else if (is_rex) begin
              rex_seen <= 1'b1;
              rex_bits <= in_data[3:0];
            end else if (is_vex) begin
              st <= S_LEAD;
              form3 <= ~in_data[0];
            end else begin
              leg_seen <= 1'b0;
              rex_seen <= 1'b0;
            end
          end
          S_LEAD: begin
            if (form3) begin
              {ax_r, ax_x, ax_b} <= ~in_data[7:5];
              ax_map <= in_data[4:0];
              st <= S_PAY2;
            end else begin
              ax_r <= ~in_data[7];
              ax_x <= 1'b0;
              ax_b <= 1'b0;
              ax_w <= 1'b0;
              ax_vvvv <= ~in_data[6:3];
              ax_l <= in_data[2];
              ax_pp <= in_data[1:0];
              ax_map <= 5'd1;
              st <= S_OPC;
            end
          end
          S_PAY2: begin
            ax_w <= in_data[7];
            ax_vvvv <= ~in_data[6:3];
            ax_l <= in_data[2];
            ax_pp <= in_data[1:0];
            st <= S_OPC;
          end
          default: begin
            st <= S_IDLE;
            leg_seen <= 1'b0;
            rex_seen <= 1'b0;
          end
        endcase
      end

      if (pass_fire) begin
        st <= S_IDLE;
        leg_seen <= 1'b0;
        rex_seen <= 1'b0;
      end

      if (emit_plain) begin
        rec_valid <= 1'b1;
        rec_vec <= 1'b0;
        rec_rex <= rex_seen;
        rec_passthru <= 1'b0;
        rec_illegal <= 1'b0;
        {rec_w, rec_r, rec_x, rec_b} <= rex_seen ? rex_bits : 4'h0;
        rec_vvvv <= '0;
        rec_l <= 1'b0;
        rec_simd <= '0;
        rec_map <= '0;
        rec_opcode <= in_data;
      end

      if (emit_vec) begin
        rec_valid <= 1'b1;
        rec_vec <= 1'b1;
        rec_rex <= 1'b0;
        rec_passthru <= 1'b0;
        rec_illegal <= leg_seen || rex_seen || map_bad;
        rec_w <= ax_w;
        rec_r <= ax_r & mode64;
        rec_x <= ax_x & mode64;
        rec_b <= ax_b & mode64;
        rec_vvvv <= ax_vvvv;
        rec_l <= ax_l;
        rec_simd <= pp_code(ax_pp);
        rec_map <= ax_map;
        rec_opcode <= in_data;
      end

      if (pass_fire) begin
        rec_valid <= 1'b1;
        rec_vec <= 1'b0;
        rec_rex <= 1'b0;
        rec_passthru <= 1'b1;
        rec_illegal <= 1'b0;
        {rec_w, rec_r, rec_x, rec_b} <= 4'h0;
        rec_vvvv <= '0;
        rec_l <= 1'b0;
        rec_simd <= '0;
        rec_map <= '0;
        rec_opcode <= {7'b1100010, ~form3};
      end
    end
  end

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable({rec_vec, rec_rex, rec_passthru,
      rec_illegal, rec_w, rec_r, rec_x, rec_b, rec_vvvv, rec_l, rec_simd, rec_map, rec_opcode}));

  a_r1_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |-> !in_ready);

  a_r7_lookahead: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready && !rec_valid |=> rec_valid && rec_passthru);

  a_r7_shape: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_passthru |-> !rec_vec && !rec_illegal && rec_opcode[7:1] == 7'b1100010);

  a_r5_map: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_vec && (rec_map == 5'd0 || rec_map > 5'd3) |-> rec_illegal);

  a_r8_no_ext32: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_vec && !mode64 |-> !rec_r && !rec_x && !rec_b);

endmodule

// File: tb/vpfx_stream_decoder_bench.sv
module vpfx_stream_decoder_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, mode64, in_valid, in_ready, rec_ready, rec_valid;
  logic [7:0] in_data;
  logic rec_vec, rec_rex, rec_passthru, rec_illegal, rec_w, rec_r, rec_x, rec_b, rec_l;
  logic [3:0] rec_vvvv;
  logic [7:0] rec_simd, rec_opcode;
  logic [4:0] rec_map;

  vpfx_stream_decoder u_vpfx_stream_decoder (
    .clk(clk), .rst_n(rst_n), .mode64(mode64), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_vec(rec_vec),
    .rec_rex(rec_rex), .rec_passthru(rec_passthru), .rec_illegal(rec_illegal),
    .rec_w(rec_w), .rec_r(rec_r), .rec_x(rec_x), .rec_b(rec_b), .rec_vvvv(rec_vvvv),
    .rec_l(rec_l), .rec_simd(rec_simd), .rec_map(rec_map), .rec_opcode(rec_opcode));

  int total = 0, bad = 0;
  logic [7:0]  byte_q[$];
  logic [33:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [33:0] pack(bit v, bit x_rex, bit pt, bit ill, bit [3:0] wrxb,
      bit [3:0] vv, bit l, bit [7:0] simd, bit [4:0] map, bit [7:0] op);
    return {v, x_rex, pt, ill, wrxb, vv, l, simd, map, op};
  endfunction

  function automatic logic [7:0] simd_of(bit [1:0] pp);
    case (pp)
      2'd0: return 8'h00;
      2'd1: return 8'h66;
      2'd2: return 8'hF3;
      default: return 8'hF2;
    endcase
  endfunction

  function automatic logic [7:0] rnd_leg();
    case ($urandom % 3)
      0: return 8'h66;
      1: return 8'hF3;
      default: return 8'hF2;
    endcase
  endfunction

  function automatic logic [7:0] rnd_plain_op(bit m64);
    logic [7:0] op;
    do op = 8'($urandom);
    while (op == 8'h66 || op == 8'hF2 || op == 8'hF3 || op == 8'hC4 || op == 8'hC5 ||
           (m64 && op[7:4] == 4'h4));
    return op;
  endfunction

  task automatic add_plain(bit m64, bit leg, bit rex, bit [3:0] wrxb, bit [7:0] op, string tag);
    if (leg) byte_q.push_back(rnd_leg());
    if (rex) byte_q.push_back({4'h4, wrxb});
    byte_q.push_back(op);
    exp_q.push_back(pack(0, rex, 0, 0, rex ? wrxb : 4'h0, 4'h0, 0, 8'h00, 5'd0, op));
    tag_q.push_back(tag);
  endtask

  task automatic add_vec2(bit m64, bit leg, bit rex, bit r, bit [3:0] vv, bit l, bit [1:0] pp,
      bit [7:0] op, string tag);
    if (leg) byte_q.push_back(rnd_leg());
    if (rex) byte_q.push_back({4'h4, 4'($urandom)});
    byte_q.push_back(8'hC5);
    byte_q.push_back({~r, ~vv, l, pp});
    byte_q.push_back(op);
    exp_q.push_back(pack(1, 0, 0, leg | rex, {1'b0, r & m64, 2'b00}, vv, l, simd_of(pp), 5'd1, op));
    tag_q.push_back(tag);
  endtask

  task automatic add_vec3(bit m64, bit leg, bit rex, bit r, bit x, bit b, bit [4:0] map, bit w,
      bit [3:0] vv, bit l, bit [1:0] pp, bit [7:0] op, string tag);
    bit ill;
    ill = leg | rex | (map == 0) | (map > 3);
    if (leg) byte_q.push_back(rnd_leg());
    if (rex) byte_q.push_back({4'h4, 4'($urandom)});
    byte_q.push_back(8'hC4);
    byte_q.push_back({~r, ~x, ~b, map});
    byte_q.push_back({w, ~vv, l, pp});
    byte_q.push_back(op);
    exp_q.push_back(pack(1, 0, 0, ill, {w, r & m64, x & m64, b & m64}, vv, l, simd_of(pp), map, op));
    tag_q.push_back(tag);
  endtask

  task automatic add_pass(bit leg, bit [7:0] lead, bit [7:0] nxt);
    if (leg) byte_q.push_back(rnd_leg());
    byte_q.push_back(lead);
    exp_q.push_back(pack(0, 0, 1, 0, 4'h0, 4'h0, 0, 8'h00, 5'd0, lead));
    tag_q.push_back("R7");
    add_plain(0, 0, 0, 4'h0, nxt, "R7_next");
  endtask

  task automatic chk(bit ok, string tag, logic [33:0] act, logic [33:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic drive_all();
    foreach (byte_q[i]) begin
      bit acc;
      if ($urandom % 3 == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data = 8'($urandom);
      end
      acc = 0;
      while (!acc) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_data = byte_q[i];
        #1;
        acc = in_ready;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(int n);
    int got = 0;
    bit held = 0;
    logic [33:0] hold_v = '0;
    while (got < n) begin
      logic [33:0] cur;
      @(negedge clk);
      rec_ready = ($urandom % 3 != 0);
      #1;
      cur = {rec_vec, rec_rex, rec_passthru, rec_illegal, rec_w, rec_r, rec_x, rec_b,
             rec_vvvv, rec_l, rec_simd, rec_map, rec_opcode};
      if (held) begin
        chk(rec_valid && cur == hold_v, "R1_hold", cur, hold_v);
        held = 0;
      end
      if (rec_valid && !rec_ready) begin
        chk(!in_ready, "R1_stall", {33'd0, in_ready}, 34'd0);
        held = 1;
        hold_v = cur;
      end
      if (rec_valid && rec_ready) begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cur == e, t, cur, e);
        got++;
      end
    end
    @(negedge clk);
    rec_ready = 1'b0;
  endtask

  task automatic run_batch(bit m64);
    int n;
    @(negedge clk);
    mode64 = m64;
    n = exp_q.size();
    fork
      drive_all();
      collect(n);
    join
    byte_q.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic gen_random(bit m64, int cnt);
    for (int i = 0; i < cnt; i++) begin
      int k;
      bit leg, rex;
      k = $urandom % 4;
      leg = ($urandom % 6 == 0);
      rex = m64 && ($urandom % 6 == 0);
      if (k == 0 || (k == 3 && m64)) begin
        add_plain(m64, leg, rex, 4'($urandom), rnd_plain_op(m64), rex ? "R9" : "R10");
      end else if (k == 1) begin
        bit [3:0] vv;
        bit r;
        vv = 4'($urandom);
        r = 1'($urandom);
        if (!m64) begin vv[3] = 0; r = 0; end
        add_vec2(m64, leg, rex, r, vv, 1'($urandom), 2'($urandom), 8'($urandom),
                 (leg | rex) ? "R6" : (m64 ? "R2_R4" : "R8"));
      end else if (k == 2) begin
        bit r, x;
        bit [4:0] map;
        r = 1'($urandom);
        x = 1'($urandom);
        if (!m64) begin r = 0; x = 0; end
        map = ($urandom % 4 == 0) ? 5'($urandom) : 5'(1 + $urandom % 3);
        add_vec3(m64, leg, rex, r, x, 1'($urandom), map, 1'($urandom), 4'($urandom),
                 1'($urandom), 2'($urandom), 8'($urandom),
                 (leg | rex) ? "R6" : ((map == 0 || map > 3) ? "R5" : (m64 ? "R3_R4" : "R8")));
      end else begin
        add_pass(leg, ($urandom % 2) ? 8'hC4 : 8'hC5, 8'($urandom % 64));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    rst_n = 0; mode64 = 1; in_valid = 0; in_data = 0; rec_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!rec_valid && in_ready, "R11_reset", {32'd0, rec_valid, in_ready}, 34'd1);

    add_vec3(1, 0, 0, 1, 1, 1, 5'd0, 0, 4'hF, 0, 2'd0, 8'h58, "R9_R5");
    add_plain(1, 0, 1, 4'b1011, 8'h8B, "R9");
    add_plain(1, 1, 0, 4'h0, 8'h10, "R10");
    for (int p = 0; p < 4; p++)
      add_vec3(1, 0, 0, 0, 1, 0, 5'd2, 1, 4'h9, 1, 2'(p), 8'hA0, "R4");
    add_vec2(1, 0, 0, 1, 4'h3, 1, 2'd1, 8'h77, "R2");
    run_batch(1);

    add_pass(1, 8'hC5, 8'h20);
    add_plain(0, 0, 0, 4'h0, 8'h41, "R9_inc32");
    add_vec2(0, 1, 0, 0, 4'h5, 0, 2'd3, 8'h12, "R6");
    add_vec3(0, 0, 0, 0, 0, 1, 5'd3, 1, 4'h2, 0, 2'd2, 8'h33, "R8");
    add_pass(0, 8'hC4, 8'h3F);
    run_batch(0);

    for (int bn = 0; bn < 16; bn++) begin
      gen_random(bn[0], 30);
      run_batch(bn[0]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule